// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block produces a periodic event from a 16-bit down-counter. A timer clock, modelled as a single-cycle tick enable in the system clock domain, first passes a prescaler that divides it by 4 or by 256. Each prescaled tick lowers the count by one. When the count lands on zero, a sticky expiry flag is set. The next prescaled tick reloads the counter from a software-written period value, so the cycle repeats without software having to act.

Software sees a period register, a small control word and the live count. The control word holds a run enable, an interrupt enable and the expiry flag. Writing 0 to the flag bit clears the flag, and writing 1 to it has no effect. The interrupt request is a level: it stays high while the flag and the interrupt enable are both set. A freeze input, driven while a debugger halts the system, stops the timer without changing any register.

Top module: `prd_tick_timer`

## Requirements
- R1: After reset the period reads 0xFFFF, the count reads 0xFFFF, the control word (bit 0 enable, bit 1 interrupt enable, bit 2 expiry flag) reads 0, and the interrupt request is low.
- R2: While enabled and not frozen, the count falls by exactly one on each prescaled tick and changes at no other time.
- R3: With `div_sel` at 0, one prescaled tick occurs for every 4 accepted `tick_in` pulses. With `div_sel` at 1, one occurs for every 256. An accepted pulse is one that arrives while the timer is enabled, not frozen and not being written.
- R4: On the clock edge where a prescaled tick makes the count 0, the expiry flag (control bit 2) becomes 1.
- R5: A prescaled tick that arrives while the count is 0 loads the count from the period register.
- R6: A period write loads the period register and the count with the written value on the next edge, and sets the prescaler back to zero accepted pulses.
- R7: While control bit 0 is 0, the count and the prescaler hold their values.
- R8: While `freeze_in` is 1, the count and the prescaler hold their values.
- R9: A control write with bit 2 at 0 clears the expiry flag. A control write with bit 2 at 1 leaves the flag unchanged. Bits 0 and 1 take the written values.
- R10: If an expiry and a clearing control write fall on the same edge, the flag ends up at 1.
- R11: `irq_o` is 1 exactly when the expiry flag and control bit 1 are both 1.
- R12: Once set, the flag stays at 1 through further expiries and reloads until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Timer clock enable, one cycle per timer clock |
| freeze_in | input | 1 | Stops the timer while high |
| div_sel | input | 1 | Prescaler choice: 0 divides by 4, 1 by 256 |
| wr_period | input | 1 | Period write strobe |
| period_wdata | input | 16 | Period write data |
| wr_ctrl | input | 1 | Control write strobe |
| ctrl_wdata | input | 3 | Control write data: enable, interrupt enable, flag clear (0 clears) |
| period_o | output | 16 | Period register readback |
| count_o | output | 16 | Live count readback |
| ctrl_o | output | 3 | Control readback: enable, interrupt enable, expiry flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench places a clearing control write on the exact edge of an expiry. A design that lets the clear win loses that event, and the flag reads 0. It writes the period after a part-finished prescale count, so a design that keeps the old prescaler state steps the counter too early. It lets the counter expire a second time while the flag is already set, and it holds the timer with the enable bit and with freeze. A leaky hold shows up as a moving count. Both divide ratios are exercised, and a long random run with period writes, including period 0, is compared every clock against a behavioural model.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;
    localparam int CNT_W     = 16;
    localparam int CTRL_W    = 3;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_FLAG = 2;
    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic             en;
        logic             ie;
    } regs_t;
endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic sel,
    output logic ptick
);
    localparam int PRE_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
    localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(DIV_LO - 1);
    localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(DIV_HI - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic             wrap;

    always_comb begin
        st_d  = st_q;
        limit = sel ? LIM_HI : LIM_LO;
        wrap  = (st_q.cnt >= limit);
        ptick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (wrap) begin
                st_d.cnt = '0;
                ptick    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prd_down_counter.sv
module prd_down_counter
    import prd_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dc_t;

    dc_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step) begin
            if (st_q.cnt == '0) st_d.cnt = period;
            else                st_d.cnt = st_q.cnt - 1'b1;
            expire = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: PERIOD_RST};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/prd_status_flag.sv
module prd_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } fl_t;

    fl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flag = 1'b0;
        if (set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/prd_tick_timer.sv
module prd_tick_timer
    import prd_timer_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              freeze_in,
    input  logic              div_sel,
    input  logic              wr_period,
    input  logic [CNT_W-1:0]  period_wdata,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o
);
    regs_t regs_d, regs_q;
    logic  adv, ptick, expire, flag, flag_clr;

    always_comb begin
        regs_d = regs_q;
        if (wr_period) regs_d.period = period_wdata;
        if (wr_ctrl) begin
            regs_d.en = ctrl_wdata[CTRL_EN];
            regs_d.ie = ctrl_wdata[CTRL_IE];
        end
        adv      = tick_in && !freeze_in && regs_q.en;
        flag_clr = wr_ctrl && !ctrl_wdata[CTRL_FLAG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{period: PERIOD_RST, en: 1'b0, ie: 1'b0};
        else        regs_q <= regs_d;
    end

    prd_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (wr_period),
        .sel   (div_sel),
        .ptick (ptick)
    );

    prd_down_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_period),
        .load_val (period_wdata),
        .step     (ptick),
        .period   (regs_q.period),
        .cnt      (count_o),
        .expire   (expire)
    );

    prd_status_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (flag_clr),
        .flag  (flag)
    );

    assign period_o = regs_q.period;
    assign ctrl_o   = {flag, regs_q.ie, regs_q.en};
    assign irq_o    = flag && regs_q.ie;
endmodule

// File: rtl/prd_tick_timer_chk.sv
module prd_tick_timer_chk
    import prd_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              freeze_in,
    input logic              wr_period,
    input logic [CNT_W-1:0]  period_wdata,
    input logic              wr_ctrl,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic [CNT_W-1:0]  period_o,
    input logic [CNT_W-1:0]  count_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              irq_o
);
    p_period_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> (count_o == $past(period_wdata)) && (period_o == $past(period_wdata)));

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[CTRL_EN] && !wr_period) |=> $stable(count_o));

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_in && !wr_period) |=> $stable(count_o));

    p_flag_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_o[CTRL_FLAG]) |-> (count_o == '0));

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[CTRL_FLAG] && !(wr_ctrl && !ctrl_wdata[CTRL_FLAG])) |=> ctrl_o[CTRL_FLAG]);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctrl_o[CTRL_FLAG] && ctrl_o[CTRL_IE]));
endmodule

bind prd_tick_timer prd_tick_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freeze_in    (freeze_in),
    .wr_period    (wr_period),
    .period_wdata (period_wdata),
    .wr_ctrl      (wr_ctrl),
    .ctrl_wdata   (ctrl_wdata),
    .period_o     (period_o),
    .count_o      (count_o),
    .ctrl_o       (ctrl_o),
    .irq_o        (irq_o)
);

// File: tb/prd_tick_timer_tb_top.sv
module prd_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0, freeze_in = 1'b0, div_sel = 1'b0;
    logic        wr_period = 1'b0, wr_ctrl = 1'b0;
    logic [15:0] period_wdata = '0;
    logic [2:0]  ctrl_wdata = '0;
    logic [15:0] period_o, count_o;
    logic [2:0]  ctrl_o;
    logic        irq_o;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;

    int m_per, m_cnt, m_pre, m_en, m_ie, m_flag;

    always #5 clk = ~clk;

    prd_tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .freeze_in(freeze_in),
        .div_sel(div_sel), .wr_period(wr_period), .period_wdata(period_wdata),
        .wr_ctrl(wr_ctrl), .ctrl_wdata(ctrl_wdata), .period_o(period_o),
        .count_o(count_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated from the sampled inputs at each edge
    always @(posedge clk) begin
        int div;
        bit exp_ev;
        cycles++;
        if (!rst_n) begin
            m_per = 65535; m_cnt = 65535; m_pre = 0;
            m_en = 0; m_ie = 0; m_flag = 0;
        end else begin
            exp_ev = 1'b0;
            div = div_sel ? 256 : 4;
            if (wr_period) begin
                m_per = period_wdata; m_cnt = period_wdata; m_pre = 0;
            end else if (m_en == 1 && tick_in && !freeze_in) begin
                m_pre = m_pre + 1;
                if (m_pre >= div) begin
                    m_pre = 0;
                    if (m_cnt == 0) m_cnt = m_per;
                    else            m_cnt = m_cnt - 1;
                    if (m_cnt == 0) exp_ev = 1'b1;
                end
            end
            if (wr_ctrl) begin
                m_en = ctrl_wdata[0]; m_ie = ctrl_wdata[1];
                if (!ctrl_wdata[2]) m_flag = 0;
            end
            if (exp_ev) m_flag = 1;
        end
    end

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R5 count vs model", count_o, m_cnt);
            chk("R6 period vs model", period_o, m_per);
            chk("R9 enable/ie vs model", ctrl_o[1:0], m_ie*2 + m_en);
            chk("R4/R12 flag vs model", ctrl_o[2], m_flag);
            chk("R11 irq vs model", irq_o, (m_flag && m_ie) ? 1 : 0);
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1;
            @(negedge clk);
        end
        tick_in = 1'b0;
    endtask

    task automatic wperiod(int v);
        wr_period = 1'b1; period_wdata = 16'(v);
        @(negedge clk);
        wr_period = 1'b0;
    endtask

    task automatic wctrl(int v);
        wr_ctrl = 1'b1; ctrl_wdata = 3'(v);
        @(negedge clk);
        wr_ctrl = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 period", period_o, 16'hFFFF);
        chk("R1 count", count_o, 16'hFFFF);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 irq", irq_o, 0);

        wperiod(3);
        chk("R6 count after period write", count_o, 3);
        wctrl(3'b111);                 // enable, irq enable, flag bit 1 = keep
        ticks(4);
        chk("R3 one step after 4 ticks", count_o, 2);
        ticks(8);
        chk("R2 count at zero", count_o, 0);
        chk("R4 flag set at zero", ctrl_o[2], 1);
        chk("R11 irq high", irq_o, 1);
        ticks(4);
        chk("R5 reload from period", count_o, 3);
        ticks(12);
        chk("R12 flag still set after second expiry", ctrl_o[2], 1);
        wctrl(3'b101);                 // ie off, flag bit 1 leaves flag
        chk("R9 flag kept by write of 1", ctrl_o[2], 1);
        chk("R11 irq low with ie off", irq_o, 0);
        wctrl(3'b011);
        chk("R9 flag cleared", ctrl_o[2], 0);
        chk("R11 irq low after clear", irq_o, 0);

        // R10: clear and expiry on the same edge
        ticks(4);                      // 0 -> reload 3
        ticks(8);                      // 3 -> 1
        ticks(3);                      // prescaler at 3
        tick_in = 1'b1; wr_ctrl = 1'b1; ctrl_wdata = 3'b011;
        @(negedge clk);
        tick_in = 1'b0; wr_ctrl = 1'b0;
        chk("R10 count reached zero", count_o, 0);
        chk("R10 set wins over clear", ctrl_o[2], 1);

        // R7: disabled holds
        wctrl(3'b110);
        ticks(20);
        chk("R7 count held when disabled", count_o, 0);
        wctrl(3'b011);
        // R8: freeze holds
        freeze_in = 1'b1;
        ticks(20);
        chk("R8 count held when frozen", count_o, 0);
        freeze_in = 1'b0;

        // R6: period write clears the prescaler
        ticks(2);
        wperiod(5);
        chk("R6 count loaded", count_o, 5);
        ticks(3);
        chk("R6 no step after 3 ticks", count_o, 5);
        ticks(1);
        chk("R6 step after 4th tick", count_o, 4);

        // R3: divide by 256
        div_sel = 1'b1;
        wperiod(2);
        ticks(255);
        chk("R3 no step after 255 ticks", count_o, 2);
        ticks(1);
        chk("R3 step after 256 ticks", count_o, 1);
        div_sel = 1'b0;

        // Random run against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            tick_in   = (r < 70);
            freeze_in = ($urandom_range(0, 19) == 0);
            wr_period = ($urandom_range(0, 149) == 0);
            period_wdata = 16'($urandom_range(0, 9));
            wr_ctrl   = ($urandom_range(0, 59) == 0);
            ctrl_wdata = 3'($urandom_range(0, 7)) | 3'b001;
            @(negedge clk);
        end
        tick_in = 1'b0; freeze_in = 1'b0; wr_period = 1'b0; wr_ctrl = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule